// File: doc/BRIEF.md
# Two-Player Reaction Race Controller

This block runs a reaction race between two players. A start press arms the round and lights the red lamp for a fixed hold-off. When the hold-off ends the green lamp comes on and an elapsed-time counter starts advancing once per clock. The first player to press after the green cue takes the lead. The counter keeps running until the other player also presses. The round then closes, the controller returns to idle and a 2-bit winner code is latched.

A press by either player while the red lamp is lit is a false start. It abandons the round without naming anyone. The winner code drives a dedicated active-low seven-segment digit. That digit shows 1 or 2 for the winner and a full 8 when no result is held. The code stays held through idle until the next start press or a reset. Buttons are assumed clean and synchronous; debouncing is done elsewhere.

Top module: `race_ctrl`

## Requirements
- R1: After a synchronous active-high reset, both lamps are off, `elapsed` is 0, `winner` is 00 and `win_seg` is 7'b0000000 (the "8" pattern). A reset at any point, including mid-race, brings the block back to this state.
- R2: A `start_btn` press in idle lights red (green off), clears `elapsed` to 0 and clears `winner` to 00. Red then stays lit for exactly WAIT_CYC cycles while `elapsed` holds at 0.
- R3: After the hold-off, green lights and red goes off. `elapsed` then rises by exactly 1 on every clock while green is lit.
- R4: A press by either player while red is lit returns the block to idle. Both lamps go off, `winner` stays 00, `elapsed` stays 0, and green does not appear later in that round.
- R5: The first press after green makes that player the leader. Green stays lit, `elapsed` keeps counting and `winner` stays 00.
- R6: While a leader is held, a press by the other player ends the round. Both lamps go off and `elapsed` freezes at its value after that cycle's increment. `winner` becomes 01 if player one led and 10 if player two led.
- R7: If both players press in the same cycle after green, player one becomes the leader.
- R8: A further press by the current leader is ignored: green stays lit and counting continues.
- R9: `start_btn` has no effect outside idle. During a race it neither clears nor stops `elapsed`.
- R10: `elapsed` saturates at 2^CNT_W-1 and does not wrap.
- R11: `win_seg` is active low with bit order {g,f,e,d,c,b,a}. It shows 7'b1111001 ("1") for code 01, 7'b0100100 ("2") for code 10, and 7'b0000000 ("8") for 00 or 11. It changes on the same edge as `winner`.
- R12: After a round ends, `winner`, `win_seg` and `elapsed` hold unchanged in idle until the next start press or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start press, honoured only in idle |
| p1_btn | input | 1 | Player one react button |
| p2_btn | input | 1 | Player two react button |
| red_led | output | 1 | Hold-off lamp |
| green_led | output | 1 | Go cue, lit for the whole race |
| elapsed | output | CNT_W | Cycles counted since the go cue |
| winner | output | 2 | 00 none, 01 player one, 10 player two |
| win_seg | output | 7 | Active-low winner digit {g,f,e,d,c,b,a} |

## Verification
Races are run with player one leading and with player two leading. The final code, the digit pattern and the frozen count then show that the lead state is chosen by the first press and the round is closed by the second. A same-cycle press by both players tells the stated tie rule apart from a symmetric or undefined choice. Repeated leader presses and start presses mid-race show these inputs do not disturb counting. False starts during red, a long race past the counter's top, and reset mid-race cover the abandon, saturation and recovery paths. A start press after a finished round shows the latched result being cleared.

// File: rtl/race_pkg.sv
`timescale 1ns/1ps
package race_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_GO    = 3'd2,
    ST_LEAD1 = 3'd3,
    ST_LEAD2 = 3'd4
  } race_st_t;

  localparam logic [1:0] WIN_NONE = 2'b00;
  localparam logic [1:0] WIN_P1   = 2'b01;
  localparam logic [1:0] WIN_P2   = 2'b10;

  localparam logic [6:0] SEG_ONE   = 7'b1111001;
  localparam logic [6:0] SEG_TWO   = 7'b0100100;
  localparam logic [6:0] SEG_EIGHT = 7'b0000000;
endpackage

// File: rtl/race_holdoff.sv
`timescale 1ns/1ps
module race_holdoff #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int WW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [WW-1:0] LAST = WW'(WAIT_CYC - 1);

  logic [WW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst || clr) tick_q <= '0;
    else if (en && tick_q != LAST) tick_q <= tick_q + 1'b1;
  end

  assign done = en && (tick_q == LAST);
endmodule

// File: rtl/race_counter.sv
`timescale 1ns/1ps
module race_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else if (en && value != TOP) value <= value + 1'b1;
  end
endmodule

// File: rtl/race_fsm.sv
`timescale 1ns/1ps
module race_fsm
  import race_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_btn,
  input  logic       p1_btn,
  input  logic       p2_btn,
  input  logic       hold_done,
  output logic       hold_clr,
  output logic       hold_en,
  output logic       cnt_clr,
  output logic       cnt_en,
  output logic       red_q,
  output logic       green_q,
  output logic [1:0] win_q,
  output logic [1:0] win_nxt
);
  race_st_t st_q, st_nxt;

  always_comb begin
    st_nxt  = st_q;
    win_nxt = win_q;
    unique case (st_q)
      ST_IDLE: if (start_btn) begin
        st_nxt  = ST_ARM;
        win_nxt = WIN_NONE;
      end
      ST_ARM: begin
        if (p1_btn || p2_btn) st_nxt = ST_IDLE;
        else if (hold_done)   st_nxt = ST_GO;
      end
      ST_GO: begin
        if (p1_btn)      st_nxt = ST_LEAD1;
        else if (p2_btn) st_nxt = ST_LEAD2;
      end
      ST_LEAD1: if (p2_btn) begin
        st_nxt  = ST_IDLE;
        win_nxt = WIN_P1;
      end
      ST_LEAD2: if (p1_btn) begin
        st_nxt  = ST_IDLE;
        win_nxt = WIN_P2;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign hold_clr = (st_q == ST_IDLE) && start_btn;
  assign cnt_clr  = hold_clr;
  assign hold_en  = (st_q == ST_ARM);
  assign cnt_en   = (st_q == ST_GO) || (st_q == ST_LEAD1) || (st_q == ST_LEAD2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      win_q   <= WIN_NONE;
      red_q   <= 1'b0;
      green_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      win_q   <= win_nxt;
      red_q   <= (st_nxt == ST_ARM);
      green_q <= (st_nxt == ST_GO) || (st_nxt == ST_LEAD1) || (st_nxt == ST_LEAD2);
    end
  end
endmodule

// File: rtl/race_windigit.sv
`timescale 1ns/1ps
module race_windigit
  import race_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code_nxt,
  output logic [6:0] seg
);
  logic [6:0] pat;

  always_comb begin
    unique case (code_nxt)
      WIN_P1:  pat = SEG_ONE;
      WIN_P2:  pat = SEG_TWO;
      default: pat = SEG_EIGHT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) seg <= SEG_EIGHT;
    else     seg <= pat;
  end
endmodule

// File: rtl/race_ctrl.sv
`timescale 1ns/1ps
module race_ctrl #(
  parameter int WAIT_CYC = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_btn,
  input  logic             p1_btn,
  input  logic             p2_btn,
  output logic             red_led,
  output logic             green_led,
  output logic [CNT_W-1:0] elapsed,
  output logic [1:0]       winner,
  output logic [6:0]       win_seg
);
  logic hold_done, hold_clr, hold_en, cnt_clr, cnt_en;
  logic [1:0] win_nxt;

  race_fsm u_fsm (
    .clk(clk), .rst(rst), .start_btn(start_btn), .p1_btn(p1_btn), .p2_btn(p2_btn),
    .hold_done(hold_done), .hold_clr(hold_clr), .hold_en(hold_en),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .red_q(red_led), .green_q(green_led),
    .win_q(winner), .win_nxt(win_nxt)
  );

  race_holdoff #(.WAIT_CYC(WAIT_CYC)) u_hold (
    .clk(clk), .rst(rst), .clr(hold_clr), .en(hold_en), .done(hold_done)
  );

  race_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en), .value(elapsed)
  );

  race_windigit u_digit (
    .clk(clk), .rst(rst), .code_nxt(win_nxt), .seg(win_seg)
  );
endmodule

// File: rtl/race_ctrl_chk.sv
`timescale 1ns/1ps
module race_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_btn,
  input logic             red_led,
  input logic             green_led,
  input logic [CNT_W-1:0] elapsed,
  input logic [1:0]       winner,
  input logic [6:0]       win_seg
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R2
  lamps_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(red_led && green_led));

  // R2
  armed_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
    red_led |-> (elapsed == '0 && winner == 2'b00));

  // R3
  race_counts_chk: assert property (@(posedge clk) disable iff (rst)
    green_led |=> (elapsed == $past(elapsed) + CNT_W'(1)) || ($past(elapsed) == TOP));

  // R12
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!red_led && !green_led && !start_btn) |=> ($stable(winner) && $stable(elapsed) && $stable(win_seg)));

  // R11
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    winner != 2'b11);

  // R11
  digit_matches_chk: assert property (@(posedge clk) disable iff (rst)
    (winner == 2'b01 && win_seg == 7'b1111001) ||
    (winner == 2'b10 && win_seg == 7'b0100100) ||
    (winner == 2'b00 && win_seg == 7'b0000000));

  // R6
  result_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (winner != 2'b00) |-> (!red_led && !green_led));
endmodule

bind race_ctrl race_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_btn(start_btn), .red_led(red_led),
  .green_led(green_led), .elapsed(elapsed), .winner(winner), .win_seg(win_seg)
);

// File: tb/race_ctrl_tb.sv
`timescale 1ns/1ps
module race_ctrl_tb;
  localparam int WAIT_CYC = 16;
  localparam int CNT_W    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_btn = 1'b0, p1_btn = 1'b0, p2_btn = 1'b0;
  logic red_led, green_led;
  logic [CNT_W-1:0] elapsed;
  logic [1:0] winner;
  logic [6:0] win_seg;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  race_ctrl #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start_btn(start_btn), .p1_btn(p1_btn), .p2_btn(p2_btn),
    .red_led(red_led), .green_led(green_led), .elapsed(elapsed),
    .winner(winner), .win_seg(win_seg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic a, input logic b);
    start_btn = s; p1_btn = a; p2_btn = b;
    @(negedge clk);
    start_btn = 1'b0; p1_btn = 1'b0; p2_btn = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic arm_and_go();
    pulse(1'b1, 1'b0, 1'b0);
    cyc(WAIT_CYC);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "red", red_led, 0);
    chk("R1", "green", green_led, 0);
    chk("R1", "elapsed", elapsed, 0);
    chk("R1", "winner", winner, 0);
    chk("R1", "seg", win_seg, 7'b0000000);
  endtask

  task automatic t_race(input bit p1_leads, input int a, input int b);
    int exp_code = p1_leads ? 1 : 2;
    int exp_seg  = p1_leads ? 7'b1111001 : 7'b0100100;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2", "red after start", red_led, 1);
    chk("R2", "green after start", green_led, 0);
    chk("R2", "elapsed cleared", elapsed, 0);
    chk("R2", "winner cleared", winner, 0);
    cyc(WAIT_CYC - 1);
    chk("R2", "red at end of hold-off", red_led, 1);
    chk("R2", "elapsed held during hold-off", elapsed, 0);
    cyc(1);
    chk("R3", "green after hold-off", green_led, 1);
    chk("R3", "red off after hold-off", red_led, 0);
    cyc(a);
    chk("R3", "elapsed counting", elapsed, a);
    pulse(1'b0, p1_leads, !p1_leads);
    chk("R5", "green kept after lead", green_led, 1);
    chk("R5", "elapsed after lead", elapsed, a + 1);
    chk("R5", "winner still none", winner, 0);
    pulse(1'b0, p1_leads, !p1_leads);
    chk("R8", "leader repeat keeps green", green_led, 1);
    chk("R8", "leader repeat keeps counting", elapsed, a + 2);
    cyc(b);
    pulse(1'b0, !p1_leads, p1_leads);
    chk("R6", "green off at close", green_led, 0);
    chk("R6", "red off at close", red_led, 0);
    chk("R6", "winner code", winner, exp_code);
    chk("R6", "elapsed frozen value", elapsed, a + b + 3);
    chk("R11", "winner digit", win_seg, exp_seg);
    cyc(5);
    chk("R12", "winner held in idle", winner, exp_code);
    chk("R12", "elapsed held in idle", elapsed, a + b + 3);
    chk("R12", "digit held in idle", win_seg, exp_seg);
  endtask

  task automatic t_clear_on_start();
    pulse(1'b1, 1'b0, 1'b0);
    chk("R12", "start clears winner", winner, 0);
    chk("R11", "digit back to 8", win_seg, 7'b0000000);
    chk("R2", "start clears elapsed", elapsed, 0);
    do_reset();
  endtask

  task automatic t_false_start();
    pulse(1'b1, 1'b0, 1'b0);
    cyc(3);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R4", "red off after false start", red_led, 0);
    chk("R4", "green off after false start", green_led, 0);
    chk("R4", "winner none after false start", winner, 0);
    chk("R4", "elapsed zero after false start", elapsed, 0);
    cyc(WAIT_CYC + 4);
    chk("R4", "no green later", green_led, 0);
    chk("R11", "digit 8 after false start", win_seg, 7'b0000000);
  endtask

  task automatic t_tie();
    arm_and_go();
    cyc(2);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R7", "green kept after tie", green_led, 1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R7", "tie goes to player one", winner, 1);
    chk("R7", "round closed by player two", green_led, 0);
  endtask

  task automatic t_start_midrace();
    arm_and_go();
    cyc(4);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R9", "start in race keeps green", green_led, 1);
    chk("R9", "start in race keeps counting", elapsed, 5);
    chk("R9", "start in race no red", red_led, 0);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6", "player two wins", winner, 2);
    chk("R6", "elapsed after close", elapsed, 7);
  endtask

  task automatic t_saturate();
    arm_and_go();
    cyc(300);
    chk("R10", "elapsed saturates", elapsed, 255);
    chk("R10", "green still on", green_led, 1);
  endtask

  task automatic t_reset_midrace();
    arm_and_go();
    cyc(3);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk("R1", "mid-race reset green", green_led, 0);
    chk("R1", "mid-race reset elapsed", elapsed, 0);
    chk("R1", "mid-race reset winner", winner, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_race(1'b1, 5, 3);
    t_clear_on_start();
    t_race(1'b0, 2, 6);
    t_false_start();
    t_tie();
    t_start_midrace();
    t_saturate();
    t_reset_midrace();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule